// File: doc/BRIEF.md
# Fractional-N Synthesizer Rate Evaluator

This block works out the output frequency that a fractional-N frequency synthesizer produces from three of its control register words and the frequency of its reference input. From those words it takes five fields: an integer feedback multiplier, a fractional numerator, a fractional denominator, a pre-divider on the reference, and a post-divider on the oscillator. The result is an integer rate in hertz.

Some field combinations are well-known operating points, and each of these has an exact rate. The block first checks the five raw fields against a built-in list of such points. If it finds a match, it returns the exact rate stored for that point and skips any arithmetic. If there is no match, it decodes the two divider fields and computes the truncated quotient with a 72-bit numerator. A restoring divider produces this quotient one bit per clock.

A request is one transfer on a valid/ready pair. `req_ready` is high only while the block is idle. A request is taken in a cycle where both `req_valid` and `req_ready` are high, and `req_valid` has no effect in any other cycle. The result comes back as a single-cycle `res_valid` pulse and does not wait for the consumer. Whoever issued the request must capture `res_rate` and `res_err` in that cycle.

Top module: `fracn_rate_calc`

## Requirements
- R1: Fields are taken from fixed bit positions. The numerator is `num_word[31:2]` and the denominator is `den_word[29:0]`. The multiplier is `div_word[24:16]`, the pre-divider is `div_word[15:13]` and the post-divider is `div_word[7:0]`. All other bits of the three words are ignored.
- R2: If the five raw fields equal one of the built-in operating points, `res_rate` is that point's exact rate, whatever the value of `fref_hz`. The table is checked before any arithmetic. The built-in points, given as (multiplier, numerator/denominator, pre, post) → rate, are:
  - (121,0/1,0,6) → 484000000
  - (140,0/1,0,6) → 560000000
  - (162,50/100,0,6) → 650000000
  - (163,84/100,0,10) → 393216000
  - (166,0/1,0,8) → 498000000
  - (167,0/1,0,9) → 445333333
  - (198,0/1,0,8) → 594000000
  - (200,0/1,0,12) → 400000000
- R3: A pre-divider field of 0 divides by 1. Values 1 to 7 divide by that value.
- R4: A post-divider field of 0 divides by 2, and a field of 1 divides by 3. Any other value divides by itself.
- R5: When no table entry matches, `res_rate = floor(fref·(mfi·mfd + mfn) / (mfd·pre·post))`. The numerator is kept at its full width, so nothing overflows.
- R6: `res_valid` is high for exactly one cycle per accepted request. For a table hit or a zero denominator it rises 2 cycles after the accepting edge. For the arithmetic path it rises 75 cycles after that edge: 3 cycles plus one per numerator bit, with 72 numerator bits.
- R7: `req_ready` is low from the accepting edge until `res_valid` has been seen. Any `req_valid` offered during that time is ignored and does not change the result that is in progress.
- R8: If there is no table match and the denominator field is 0, the block does not divide. `res_rate` is 0 and `res_err` is 1. In every other case `res_err` is 0.
- R9: After reset `req_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken in this cycle |
| num_word | input | 32 | Numerator register word |
| den_word | input | 32 | Denominator register word |
| div_word | input | 32 | Divider register word (multiplier, pre-divider, post-divider) |
| fref_hz | input | 32 | Reference frequency in Hz |
| res_valid | output | 1 | Result pulse, one cycle |
| res_rate | output | 64 | Computed output frequency in Hz |
| res_err | output | 1 | Denominator was zero |

## Verification
Two events can fall in the same cycle: the result pulse of one request and a new request from the producer. A new `req_valid` may arrive while `res_valid` is high. The bench creates this case by holding `req_valid` high with different data both while the block is busy and in the cycle of the result pulse. A behavioural model, updated every clock, predicts that the held request is taken only in the cycle after the pulse. The bench then checks that `req_ready`, `res_valid`, `res_rate` and `res_err` match the model's prediction in every cycle.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  localparam int WORD_W     = 32;
  localparam int MFI_W      = 9;
  localparam int FRAC_W     = 30;
  localparam int RDIV_W     = 3;
  localparam int ODIV_W     = 8;
  localparam int TAB_RATE_W = 32;
  localparam int NUM_CFG    = 8;

  // bit positions inside the register words
  localparam int MFN_LSB  = 2;
  localparam int MFD_LSB  = 0;
  localparam int MFI_LSB  = 16;
  localparam int RDIV_LSB = 13;
  localparam int ODIV_LSB = 0;

  typedef struct packed {
    logic [MFI_W-1:0]  mfi;
    logic [FRAC_W-1:0] mfn;
    logic [FRAC_W-1:0] mfd;
    logic [RDIV_W-1:0] rdiv;
    logic [ODIV_W-1:0] odiv;
  } cfg_t;

  typedef struct packed {
    cfg_t                  cfg;
    logic [TAB_RATE_W-1:0] rate;
  } point_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_DIV, ST_DONE} state_t;

  function automatic point_t mk_point(input int unsigned r, input int unsigned i,
                                      input int unsigned n, input int unsigned d,
                                      input int unsigned p, input int unsigned o);
    point_t pt;
    pt.rate     = TAB_RATE_W'(r);
    pt.cfg.mfi  = MFI_W'(i);
    pt.cfg.mfn  = FRAC_W'(n);
    pt.cfg.mfd  = FRAC_W'(d);
    pt.cfg.rdiv = RDIV_W'(p);
    pt.cfg.odiv = ODIV_W'(o);
    return pt;
  endfunction

  // Known operating points, ordered by multiplier
  function automatic point_t known_point(input int idx);
    case (idx)
      0:       return mk_point(484000000, 121, 0, 1, 0, 6);
      1:       return mk_point(560000000, 140, 0, 1, 0, 6);
      2:       return mk_point(650000000, 162, 50, 100, 0, 6);
      3:       return mk_point(393216000, 163, 84, 100, 0, 10);
      4:       return mk_point(498000000, 166, 0, 1, 0, 8);
      5:       return mk_point(445333333, 167, 0, 1, 0, 9);
      6:       return mk_point(594000000, 198, 0, 1, 0, 8);
      default: return mk_point(400000000, 200, 0, 1, 0, 12);
    endcase
  endfunction

  function automatic logic [RDIV_W-1:0] eff_rdiv(input logic [RDIV_W-1:0] raw);
    return (raw == '0) ? RDIV_W'(1) : raw;
  endfunction

  function automatic logic [ODIV_W-1:0] eff_odiv(input logic [ODIV_W-1:0] raw);
    case (raw)
      ODIV_W'(0): return ODIV_W'(2);
      ODIV_W'(1): return ODIV_W'(3);
      default:    return raw;
    endcase
  endfunction

endpackage

// File: rtl/fracn_field_decode.sv
module fracn_field_decode
  import fracn_pkg::*;
(
  input  logic [WORD_W-1:0] num_word,
  input  logic [WORD_W-1:0] den_word,
  input  logic [WORD_W-1:0] div_word,
  output cfg_t              cfg
);

  logic unused_bits;

  always_comb begin
    cfg.mfn  = num_word[MFN_LSB  +: FRAC_W];
    cfg.mfd  = den_word[MFD_LSB  +: FRAC_W];
    cfg.mfi  = div_word[MFI_LSB  +: MFI_W];
    cfg.rdiv = div_word[RDIV_LSB +: RDIV_W];
    cfg.odiv = div_word[ODIV_LSB +: ODIV_W];
  end

  assign unused_bits = ^{num_word[MFN_LSB-1:0], den_word[WORD_W-1:MFD_LSB+FRAC_W],
                         div_word[WORD_W-1:MFI_LSB+MFI_W], div_word[MFI_LSB-1:RDIV_LSB+RDIV_W],
                         div_word[RDIV_LSB-1:ODIV_LSB+ODIV_W]};

endmodule

// File: rtl/fracn_cfg_match.sv
module fracn_cfg_match
  import fracn_pkg::*;
#(
  parameter int RATE_W = 64
)(
  input  cfg_t              cfg,
  output logic              hit,
  output logic [RATE_W-1:0] rate
);

  logic [NUM_CFG-1:0]    hit_vec;
  logic [TAB_RATE_W-1:0] rate_sel [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_point
    localparam point_t PT = known_point(g);
    assign hit_vec[g]  = (cfg == PT.cfg);
    assign rate_sel[g] = PT.rate;
  end

  always_comb begin
    hit  = |hit_vec;
    rate = '0;
    for (int i = NUM_CFG - 1; i >= 0; i--) begin
      if (hit_vec[i]) rate = RATE_W'(rate_sel[i]);
    end
  end

endmodule

// File: rtl/fracn_seq_div.sv
module fracn_seq_div #(
  parameter int N     = 72,
  parameter int D     = 41,
  parameter int OUT_W = 64
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N-1:0]     dividend,
  input  logic [D-1:0]     divisor,
  output logic             busy,
  output logic [OUT_W-1:0] quo
);

  localparam int CNT_W = $clog2(N + 1);

  logic [N-1:0]     q_q;
  logic [D-1:0]     rem_q;
  logic [D-1:0]     dsr_q;
  logic [CNT_W-1:0] cnt_q;

  logic [D:0] trial;
  logic [D:0] diff;
  logic       take;

  always_comb begin
    trial = {rem_q, q_q[N-1]};
    diff  = trial - {1'b0, dsr_q};
    take  = (trial >= {1'b0, dsr_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      q_q   <= dividend;
      rem_q <= '0;
      dsr_q <= divisor;
      cnt_q <= CNT_W'(N);
    end else if (cnt_q != '0) begin
      q_q   <= {q_q[N-2:0], take};
      rem_q <= take ? diff[D-1:0] : trial[D-1:0];
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign quo  = q_q[OUT_W-1:0];

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (rem_q < dsr_q)); // R5

endmodule

// File: rtl/fracn_rate_calc.sv
module fracn_rate_calc
  import fracn_pkg::*;
#(
  parameter int REF_W  = 32,
  parameter int RATE_W = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] num_word,
  input  logic [WORD_W-1:0] den_word,
  input  logic [WORD_W-1:0] div_word,
  input  logic [REF_W-1:0]  fref_hz,
  output logic              res_valid,
  output logic [RATE_W-1:0] res_rate,
  output logic              res_err
);

  localparam int MUL_W = MFI_W + FRAC_W + 1;
  localparam int NUM_W = REF_W + MUL_W;
  localparam int DEN_W = FRAC_W + RDIV_W + ODIV_W;

  state_t st_q;
  cfg_t   dec_cfg;
  cfg_t   cfg_q;
  logic [REF_W-1:0]  fref_q;
  logic [RATE_W-1:0] rate_q;
  logic              err_q;

  logic              tab_hit;
  logic [RATE_W-1:0] tab_rate;
  logic [MUL_W-1:0]  mul_term;
  logic [NUM_W-1:0]  dividend;
  logic [DEN_W-1:0]  divisor;
  logic              div_load;
  logic              div_busy;
  logic [RATE_W-1:0] div_quo;
  logic              den_zero;

  fracn_field_decode u_dec (
    .num_word (num_word),
    .den_word (den_word),
    .div_word (div_word),
    .cfg      (dec_cfg)
  );

  fracn_cfg_match #(.RATE_W(RATE_W)) u_match (
    .cfg  (cfg_q),
    .hit  (tab_hit),
    .rate (tab_rate)
  );

  always_comb begin
    mul_term = MUL_W'(cfg_q.mfi) * MUL_W'(cfg_q.mfd) + MUL_W'(cfg_q.mfn);
    dividend = NUM_W'(fref_q) * NUM_W'(mul_term);
    divisor  = DEN_W'(cfg_q.mfd) * DEN_W'(eff_rdiv(cfg_q.rdiv)) * DEN_W'(eff_odiv(cfg_q.odiv));
    den_zero = (cfg_q.mfd == '0);
    div_load = (st_q == ST_CHECK) && !tab_hit && !den_zero;
  end

  fracn_seq_div #(.N(NUM_W), .D(DEN_W), .OUT_W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .dividend (dividend),
    .divisor  (divisor),
    .busy     (div_busy),
    .quo      (div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      fref_q <= '0;
      rate_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          cfg_q  <= dec_cfg;
          fref_q <= fref_hz;
          st_q   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (tab_hit) begin
            rate_q <= tab_rate;
            err_q  <= 1'b0;
            st_q   <= ST_DONE;
          end else if (den_zero) begin
            rate_q <= '0;
            err_q  <= 1'b1;
            st_q   <= ST_DONE;
          end else begin
            st_q   <= ST_DIV;
          end
        end
        ST_DIV: if (!div_busy) begin
          rate_q <= div_quo;
          err_q  <= 1'b0;
          st_q   <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign res_valid = (st_q == ST_DONE);
  assign res_rate  = rate_q;
  assign res_err   = err_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R7

  AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(cfg_q)); // R7

  AST_DIV_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DIV && !div_busy) |=> (res_valid && !res_err)); // R6

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_rate == '0)); // R8

endmodule

// File: tb/sim_fracn_rate_calc.sv
module sim_fracn_rate_calc;

  localparam int LAT_FAST = 2;
  localparam int LAT_DIV  = 75;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] num_word = '0;
  logic [31:0] den_word = '0;
  logic [31:0] div_word = '0;
  logic [31:0] fref_hz = '0;
  logic        res_valid;
  logic [63:0] res_rate;
  logic        res_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int          m_cnt = 0;
  logic [63:0] m_rate = '0;
  bit          m_err = 0;
  string       m_tag = "R5";
  string       cur_tag = "R5";

  always #5 clk = ~clk;

  fracn_rate_calc u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .num_word(num_word), .den_word(den_word), .div_word(div_word), .fref_hz(fref_hz),
    .res_valid(res_valid), .res_rate(res_rate), .res_err(res_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void tab_lookup(input int unsigned mfi, mfn, mfd, rd, od,
                                     output bit hit, output logic [63:0] rate);
    int unsigned t [8][6] = '{
      '{200, 0, 1, 0, 12, 400000000}, '{198, 0, 1, 0, 8, 594000000},
      '{167, 0, 1, 0, 9, 445333333},  '{166, 0, 1, 0, 8, 498000000},
      '{163, 84, 100, 0, 10, 393216000}, '{162, 50, 100, 0, 6, 650000000},
      '{140, 0, 1, 0, 6, 560000000},  '{121, 0, 1, 0, 6, 484000000}};
    hit = 0;
    rate = '0;
    foreach (t[i]) begin
      if (t[i][0] == mfi && t[i][1] == mfn && t[i][2] == mfd && t[i][3] == rd && t[i][4] == od) begin
        hit = 1;
        rate = 64'(t[i][5]);
      end
    end
  endfunction

  function automatic void ref_model(input logic [31:0] nw, dw, vw, fr,
                                    output logic [63:0] rate, output bit err, output bit fast);
    int unsigned mfi = vw[24:16];
    int unsigned mfn = nw[31:2];
    int unsigned mfd = dw[29:0];
    int unsigned rd  = vw[15:13];
    int unsigned od  = vw[7:0];
    logic [127:0] n, d;
    bit hit;
    tab_lookup(mfi, mfn, mfd, rd, od, hit, rate);
    err = 0;
    fast = 1;
    if (hit) return;
    if (mfd == 0) begin
      rate = '0;
      err = 1;
      return;
    end
    fast = 0;
    if (rd == 0) rd = 1;
    if (od == 0) od = 2;
    else if (od == 1) od = 3;
    n = 128'(fr) * (128'(mfi) * 128'(mfd) + 128'(mfn));
    d = 128'(mfd) * 128'(rd) * 128'(od);
    rate = 64'(n / d);
  endfunction

  // per-cycle reference model, sampled between edges
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(req_ready == (m_cnt == 0), "R7 ready", 64'(req_ready), 64'(m_cnt == 0));
      chk(res_valid == (m_cnt == 1), "R6 valid", 64'(res_valid), 64'(m_cnt == 1));
      if (m_cnt == 1 && res_valid) begin
        chk(res_rate == m_rate, m_tag, res_rate, m_rate);
        chk(res_err == m_err, "R8 err", 64'(res_err), 64'(m_err));
      end
      if (m_cnt == 0) begin
        if (req_valid) begin
          bit fast;
          ref_model(num_word, den_word, div_word, fref_hz, m_rate, m_err, fast);
          m_tag = cur_tag;
          m_cnt = fast ? LAT_FAST : LAT_DIV;
        end
      end else begin
        m_cnt--;
      end
    end
  end

  function automatic logic [31:0] mk_div(input int unsigned mfi, rd, od);
    return (32'(mfi) << 16) | (32'(rd) << 13) | 32'(od);
  endfunction

  task automatic drive(input string tag, input int unsigned mfi, mfn, mfd, rd, od, input logic [31:0] fr);
    cur_tag  = tag;
    num_word = 32'(mfn) << 2;
    den_word = 32'(mfd);
    div_word = mk_div(mfi, rd, od);
    fref_hz  = fr;
  endtask

  task automatic send(input string tag, input int unsigned mfi, mfn, mfd, rd, od, input logic [31:0] fr);
    @(posedge clk); #1;
    drive(tag, mfi, mfn, mfd, rd, od, fr);
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (LAT_DIV + 4) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready", 64'(req_ready), 64'd1);
    chk(res_valid == 1'b0, "R9 valid", 64'(res_valid), 64'd0);

    // R2: table point wins even with a reference that would give another value
    send("R2", 162, 50, 100, 0, 6, 32'd25_000_000); settle();
    send("R2", 198, 0, 1, 0, 8, 32'd27_000_000); settle();
    send("R2", 163, 84, 100, 0, 10, 32'd24_000_000); settle();
    // R3/R4: pre 0 -> 1, post 0 -> 2
    send("R3", 100, 1, 3, 0, 0, 32'd24_000_000); settle();
    // R4: post 1 -> 3, pre 2 as-is
    send("R4", 150, 0, 1, 2, 1, 32'd24_000_000); settle();
    // R4: post value outside the table's combination
    send("R4", 163, 84, 100, 0, 5, 32'd24_000_000); settle();
    // R5: truncation
    send("R5", 7, 1, 3, 3, 7, 32'd10_000_001); settle();
    // R5: widest operands
    send("R5", 511, 32'h3FFF_FFFF, 32'h3FFF_FFFF, 1, 2, 32'hFFFF_FFFF); settle();
    // R8: zero denominator
    send("R8", 90, 5, 0, 0, 4, 32'd24_000_000); settle();
    // R1: junk in unused bit positions must not matter
    @(posedge clk); #1;
    drive("R1", 140, 0, 1, 0, 6, 32'd19_200_000);
    num_word = num_word | 32'h3;
    den_word = den_word | 32'hC000_0000;
    div_word = div_word | 32'hFE00_1F00;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 1'b0;
    settle();
    // R7: requests during busy and in the result cycle are ignored
    send("R7", 120, 3, 7, 4, 9, 32'd33_333_333);
    drive("R8", 55, 0, 0, 0, 0, 32'd1);
    req_valid = 1'b1;
    repeat (LAT_DIV + 2) @(posedge clk);
    #1 req_valid = 1'b0;
    settle();
    // back-to-back requests
    send("R5", 13, 999, 1000, 5, 200, 32'd50_000_000);
    send("R2", 121, 0, 1, 0, 6, 32'd1_000_000);
    settle();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule